// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block carries a processor core from normal execution into a vectored interrupt handler. When an interrupt request arrives with interrupts enabled, the block takes a snapshot of the architectural state it needs: the status word, the user-mode flag, the stack pointer, the kernel stack pointer, the program counter and the exception base. It then steps through a fixed series of register updates, issuing one write strobe per step to the core's register file. It leaves user mode. It pushes the status word by a ten-place left shift inside the same word, keeping the top bit. If the core was in user mode, it swaps to the kernel stack. It records the return address, the exception status and the exception data address.

Once the register updates are done, the block fetches the handler address through a 32-bit read port with a request/valid handshake. It waits as long as the memory takes to answer. It then either loads the program counter and pulses a completion flag, or pulses an error flag if the read failed. A busy flag covers the whole sequence, and requests that arrive while it is high are ignored.

Top module: `irq_entry_seq`

## Requirements
- R1: While `irq_en` is 0, an `irq_req` in the idle state is ignored: `busy` stays 0 and no strobe, memory request, `done` or `err` appears.
- R2: A request taken in the idle state with `irq_en` high raises `busy` in the next cycle, and that first cycle pulses `umode_clr` before any other register strobe.
- R3: In the cycle after `umode_clr`, `stat_we` pulses with `stat_out` = ((old << 10) AND 0x3FFF_FFFF) OR (old AND 0x8000_0000), where old is the status word captured at acceptance.
- R4: Only when `user_mode` was 1 at acceptance, the cycle after `stat_we` pulses both `usp_we` (with `usp_out` = captured stack pointer) and `sp_we` (with `sp_out` = captured kernel stack pointer). From kernel mode neither strobe ever appears.
- R5: In the single cycle after the status step (or after the stack step when present), `ret_we` pulses with `ret_out` = captured PC, `exs_we` pulses with `exs_out` = vector × 256, and `eda_clr` pulses.
- R6: In the cycle after R5's step, `mem_req` is high for exactly one cycle with `mem_addr` = (exception base + vector × 4) modulo 2^32. `mem_rdata[7:0]` holds the byte at the lowest address, so the little-endian word is the 32-bit value `mem_rdata` as presented.
- R7: The block waits with no further strobes until `mem_valid` is sampled high in a cycle after the `mem_req` cycle. A `mem_valid` in the `mem_req` cycle itself is ignored.
- R8: When the response has `mem_err` = 0, the next cycle pulses `pc_we` and `done` together, with `pc_out` = the returned word. `busy` falls the cycle after that.
- R9: When the response has `mem_err` = 1, the next cycle pulses `err` alone, with no `pc_we` and no `done`. `busy` falls the cycle after that.
- R10: `busy` is high from the cycle after acceptance through the final `done`/`err` cycle. New requests, and changes on the state inputs, have no effect during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Interrupt request |
| irq_vec | input | VEC_W (8) | Interrupt vector number |
| irq_en | input | 1 | Interrupt enable bit of the core |
| user_mode | input | 1 | Core is in user mode |
| stat_in | input | 32 | Current status word |
| sp_in | input | 32 | Current stack pointer |
| ksp_in | input | 32 | Kernel stack pointer |
| pc_in | input | 32 | Current program counter |
| ebase_in | input | 32 | Exception vector base |
| umode_clr | output | 1 | Clear user mode |
| stat_we | output | 1 | Status word write strobe |
| stat_out | output | 32 | New status word |
| usp_we | output | 1 | User stack pointer write strobe |
| usp_out | output | 32 | Value for the user stack pointer |
| sp_we | output | 1 | Stack pointer write strobe |
| sp_out | output | 32 | Value for the stack pointer |
| ret_we | output | 1 | Return address write strobe |
| ret_out | output | 32 | Return address |
| exs_we | output | 1 | Exception status write strobe |
| exs_out | output | 32 | Exception status value |
| eda_clr | output | 1 | Clear exception data address |
| mem_req | output | 1 | Handler address read request |
| mem_addr | output | 32 | Read address |
| mem_valid | input | 1 | Read response valid |
| mem_err | input | 1 | Read response failed |
| mem_rdata | input | 32 | Read data, lowest-address byte in bits 7:0 |
| pc_we | output | 1 | Program counter write strobe |
| pc_out | output | 32 | Handler address |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Entry completed |
| err | output | 1 | Entry failed on the vector read |

## Verification
Each step of the sequence owns exactly one cycle and one set of strobes. A step that is skipped, repeated or reordered therefore shows at the ports in the very cycle it goes wrong: a strobe appears one cycle early or late, or a required one is missing. A wrong snapshot, or a capture taken after acceptance, shows as a wrong data value on the first strobe that carries it. That value comes within two to six cycles of acceptance. A fault in the response handling shows as a hang with `busy` stuck high, or as `done` and `err` in the wrong cycle. Both become visible within one cycle of the response.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int WORD_W    = 32;
    localparam int PUSH_BITS = 10;
    localparam int KEEP_LOW  = 30;
    localparam int EXS_SHIFT = 8;
    localparam int SLOT_SHIFT = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DROP_USER,
        ST_STATUS,
        ST_STACK,
        ST_SAVE,
        ST_FETCH_REQ,
        ST_FETCH_WAIT,
        ST_FINISH,
        ST_FAULT
    } step_e;

    typedef struct packed {
        logic [WORD_W-1:0] stat;
        logic [WORD_W-1:0] sp;
        logic [WORD_W-1:0] ksp;
        logic [WORD_W-1:0] pc;
        logic [WORD_W-1:0] ebase;
        logic              from_user;
    } snap_t;

    function automatic logic [WORD_W-1:0] push_status(input logic [WORD_W-1:0] old);
        logic [WORD_W-1:0] shifted;
        logic [WORD_W-1:0] low_mask;
        shifted  = old << PUSH_BITS;
        low_mask = {{(WORD_W-KEEP_LOW){1'b0}}, {KEEP_LOW{1'b1}}};
        return (shifted & low_mask) | {old[WORD_W-1], {(WORD_W-1){1'b0}}};
    endfunction

endpackage

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_entry_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  irq_req,
    input  logic  irq_en,
    input  logic  from_user,
    input  logic  mem_valid,
    input  logic  mem_err,
    output step_e step,
    output logic  accept,
    output logic  take_resp
);

    step_e step_nx;

    assign accept    = (step == ST_IDLE) && irq_req && irq_en;
    assign take_resp = (step == ST_FETCH_WAIT) && mem_valid;

    always_comb begin
        step_nx = step;
        unique case (step)
            ST_IDLE:       if (accept) step_nx = ST_DROP_USER;
            ST_DROP_USER:  step_nx = ST_STATUS;
            ST_STATUS:     step_nx = from_user ? ST_STACK : ST_SAVE;
            ST_STACK:      step_nx = ST_SAVE;
            ST_SAVE:       step_nx = ST_FETCH_REQ;
            ST_FETCH_REQ:  step_nx = ST_FETCH_WAIT;
            ST_FETCH_WAIT: if (take_resp) step_nx = mem_err ? ST_FAULT : ST_FINISH;
            ST_FINISH:     step_nx = ST_IDLE;
            ST_FAULT:      step_nx = ST_IDLE;
            default:       step_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) step <= ST_IDLE;
        else     step <= step_nx;
    end

    // R2
    accept_leaves_idle_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (step == ST_DROP_USER));

    // R7
    wait_holds_chk: assert property (@(posedge clk) disable iff (rst)
        ((step == ST_FETCH_WAIT) && !mem_valid) |=> (step == ST_FETCH_WAIT));

endmodule

// File: rtl/irq_seq_path.sv
module irq_seq_path
    import irq_entry_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              take_resp,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic              user_mode,
    input  logic [WORD_W-1:0] stat_in,
    input  logic [WORD_W-1:0] sp_in,
    input  logic [WORD_W-1:0] ksp_in,
    input  logic [WORD_W-1:0] pc_in,
    input  logic [WORD_W-1:0] ebase_in,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              from_user,
    output logic [WORD_W-1:0] stat_new,
    output logic [WORD_W-1:0] usp_val,
    output logic [WORD_W-1:0] sp_val,
    output logic [WORD_W-1:0] ret_val,
    output logic [WORD_W-1:0] exs_val,
    output logic [WORD_W-1:0] fetch_addr,
    output logic [WORD_W-1:0] handler
);

    localparam int PAD_W = WORD_W - VEC_W;

    snap_t            snap;
    logic [VEC_W-1:0] vec_q;
    logic [WORD_W-1:0] vec_wide;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap    <= '0;
            vec_q   <= '0;
            handler <= '0;
        end else begin
            if (accept) begin
                snap.stat      <= stat_in;
                snap.sp        <= sp_in;
                snap.ksp       <= ksp_in;
                snap.pc        <= pc_in;
                snap.ebase     <= ebase_in;
                snap.from_user <= user_mode;
                vec_q          <= irq_vec;
            end
            if (take_resp) handler <= mem_rdata;
        end
    end

    assign vec_wide   = {{PAD_W{1'b0}}, vec_q};
    assign from_user  = snap.from_user;
    assign stat_new   = push_status(snap.stat);
    assign usp_val    = snap.sp;
    assign sp_val     = snap.ksp;
    assign ret_val    = snap.pc;
    assign exs_val    = vec_wide << EXS_SHIFT;
    assign fetch_addr = snap.ebase + (vec_wide << SLOT_SHIFT);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_req,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic              irq_en,
    input  logic              user_mode,
    input  logic [31:0]       stat_in,
    input  logic [31:0]       sp_in,
    input  logic [31:0]       ksp_in,
    input  logic [31:0]       pc_in,
    input  logic [31:0]       ebase_in,
    output logic              umode_clr,
    output logic              stat_we,
    output logic [31:0]       stat_out,
    output logic              usp_we,
    output logic [31:0]       usp_out,
    output logic              sp_we,
    output logic [31:0]       sp_out,
    output logic              ret_we,
    output logic [31:0]       ret_out,
    output logic              exs_we,
    output logic [31:0]       exs_out,
    output logic              eda_clr,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_valid,
    input  logic              mem_err,
    input  logic [31:0]       mem_rdata,
    output logic              pc_we,
    output logic [31:0]       pc_out,
    output logic              busy,
    output logic              done,
    output logic              err
);

    step_e step;
    logic  accept;
    logic  take_resp;
    logic  from_user;

    irq_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .irq_req   (irq_req),
        .irq_en    (irq_en),
        .from_user (from_user),
        .mem_valid (mem_valid),
        .mem_err   (mem_err),
        .step      (step),
        .accept    (accept),
        .take_resp (take_resp)
    );

    irq_seq_path #(.VEC_W(VEC_W)) u_path (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .take_resp  (take_resp),
        .irq_vec    (irq_vec),
        .user_mode  (user_mode),
        .stat_in    (stat_in),
        .sp_in      (sp_in),
        .ksp_in     (ksp_in),
        .pc_in      (pc_in),
        .ebase_in   (ebase_in),
        .mem_rdata  (mem_rdata),
        .from_user  (from_user),
        .stat_new   (stat_out),
        .usp_val    (usp_out),
        .sp_val     (sp_out),
        .ret_val    (ret_out),
        .exs_val    (exs_out),
        .fetch_addr (mem_addr),
        .handler    (pc_out)
    );

    assign busy      = (step != ST_IDLE);
    assign umode_clr = (step == ST_DROP_USER);
    assign stat_we   = (step == ST_STATUS);
    assign usp_we    = (step == ST_STACK);
    assign sp_we     = (step == ST_STACK);
    assign ret_we    = (step == ST_SAVE);
    assign exs_we    = (step == ST_SAVE);
    assign eda_clr   = (step == ST_SAVE);
    assign mem_req   = (step == ST_FETCH_REQ);
    assign pc_we     = (step == ST_FINISH);
    assign done      = (step == ST_FINISH);
    assign err       = (step == ST_FAULT);

    // R1
    disabled_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && irq_req && !irq_en) |=> !busy);

    // R2
    umode_then_stat_chk: assert property (@(posedge clk) disable iff (rst)
        umode_clr |=> stat_we);

    // R4
    swap_after_status_chk: assert property (@(posedge clk) disable iff (rst)
        sp_we |-> $past(stat_we));

    // R6
    req_single_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R9
    fault_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> (!pc_we && !done));

    // R10
    one_step_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({umode_clr, stat_we, sp_we, ret_we, mem_req, pc_we, err}));

endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_req = 1'b0;
    logic [7:0]  irq_vec = '0;
    logic        irq_en = 1'b0;
    logic        user_mode = 1'b0;
    logic [31:0] stat_in = '0, sp_in = '0, ksp_in = '0, pc_in = '0, ebase_in = '0;
    logic        mem_valid = 1'b0, mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        umode_clr, stat_we, usp_we, sp_we, ret_we, exs_we, eda_clr;
    logic        mem_req, pc_we, busy, done, err;
    logic [31:0] stat_out, usp_out, sp_out, ret_out, exs_out, mem_addr, pc_out;

    int vectors = 0;
    int fails = 0;
    bit running = 0;

    always #4 clk = ~clk;

    irq_entry_seq #(.VEC_W(8)) dut_i (
        .clk(clk), .rst(rst), .irq_req(irq_req), .irq_vec(irq_vec), .irq_en(irq_en),
        .user_mode(user_mode), .stat_in(stat_in), .sp_in(sp_in), .ksp_in(ksp_in),
        .pc_in(pc_in), .ebase_in(ebase_in), .umode_clr(umode_clr), .stat_we(stat_we),
        .stat_out(stat_out), .usp_we(usp_we), .usp_out(usp_out), .sp_we(sp_we),
        .sp_out(sp_out), .ret_we(ret_we), .ret_out(ret_out), .exs_we(exs_we),
        .exs_out(exs_out), .eda_clr(eda_clr), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_err(mem_err), .mem_rdata(mem_rdata), .pc_we(pc_we),
        .pc_out(pc_out), .busy(busy), .done(done), .err(err)
    );

    // Behavioural reference: phase numbers 0 idle, 1 leave user, 2 status,
    // 3 stack, 4 save, 5 request, 6 wait, 7 success, 8 failure.
    int          m_ph = 0;
    logic [31:0] m_stat, m_sp, m_ksp, m_pc, m_eb, m_word;
    logic [7:0]  m_vec;
    logic        m_user;

    always @(posedge clk) begin
        if (rst) m_ph <= 0;
        else begin
            case (m_ph)
                0: if (irq_req && irq_en) begin
                       m_ph <= 1; m_stat <= stat_in; m_sp <= sp_in; m_ksp <= ksp_in;
                       m_pc <= pc_in; m_eb <= ebase_in; m_vec <= irq_vec; m_user <= user_mode;
                   end
                1: m_ph <= 2;
                2: m_ph <= m_user ? 3 : 4;
                3: m_ph <= 4;
                4: m_ph <= 5;
                5: m_ph <= 6;
                6: if (mem_valid) begin m_ph <= mem_err ? 8 : 7; m_word <= mem_rdata; end
                default: m_ph <= 0;
            endcase
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (running) begin
            chk("R10", "busy", 32'(busy), 32'(m_ph != 0));
            chk("R2", "umode_clr", 32'(umode_clr), 32'(m_ph == 1));
            chk("R3", "stat_we", 32'(stat_we), 32'(m_ph == 2));
            if (m_ph == 2)
                chk("R3", "stat_out", stat_out,
                    ((m_stat << 10) & 32'h3FFF_FFFF) | (m_stat & 32'h8000_0000));
            chk("R4", "usp_we", 32'(usp_we), 32'(m_ph == 3));
            chk("R4", "sp_we", 32'(sp_we), 32'(m_ph == 3));
            if (m_ph == 3) begin
                chk("R4", "usp_out", usp_out, m_sp);
                chk("R4", "sp_out", sp_out, m_ksp);
            end
            chk("R5", "ret_we", 32'(ret_we), 32'(m_ph == 4));
            chk("R5", "exs_we", 32'(exs_we), 32'(m_ph == 4));
            chk("R5", "eda_clr", 32'(eda_clr), 32'(m_ph == 4));
            if (m_ph == 4) begin
                chk("R5", "ret_out", ret_out, m_pc);
                chk("R5", "exs_out", exs_out, 32'(m_vec) * 256);
            end
            chk("R6", "mem_req", 32'(mem_req), 32'(m_ph == 5));
            if (m_ph == 5) chk("R6", "mem_addr", mem_addr, m_eb + 32'(m_vec) * 4);
            chk("R8", "pc_we", 32'(pc_we), 32'(m_ph == 7));
            chk("R8", "done", 32'(done), 32'(m_ph == 7));
            if (m_ph == 7) chk("R8", "pc_out", pc_out, m_word);
            chk("R9", "err", 32'(err), 32'(m_ph == 8));
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One interrupt entry: drive state, respond to the read after lat cycles.
    task automatic run_irq(input logic [7:0] vec, input logic usr, input logic [31:0] st,
                           input logic [31:0] sp, input logic [31:0] ksp, input logic [31:0] pc,
                           input logic [31:0] eb, input logic [31:0] word, input logic fail,
                           input int lat, input bit spurious, input bit hold);
        int guard;
        @(negedge clk);
        irq_req = 1'b1; irq_en = 1'b1; irq_vec = vec; user_mode = usr;
        stat_in = st; sp_in = sp; ksp_in = ksp; pc_in = pc; ebase_in = eb;
        @(negedge clk);
        if (!hold) irq_req = 1'b0;
        // R10: inputs changed after acceptance must not matter
        irq_vec = ~vec; user_mode = ~usr; stat_in = ~st; sp_in = sp ^ 32'h55;
        ksp_in = ~ksp; pc_in = pc + 32'h100; ebase_in = ~eb;
        guard = 0;
        while (!mem_req && guard < 50) begin @(negedge clk); guard++; end
        if (guard >= 50) begin
            fails++; $display("FAIL R6 mem_req actual=0 expected=1 (never issued)");
        end
        if (spurious) begin
            // R7: a response in the request cycle is ignored
            mem_valid = 1'b1; mem_err = 1'b1; mem_rdata = 32'hDEAD_0000;
            @(negedge clk);
            mem_valid = 1'b0; mem_err = 1'b0;
        end else begin
            @(negedge clk);
        end
        idle(lat);
        mem_valid = 1'b1; mem_err = fail; mem_rdata = word;
        @(negedge clk);
        mem_valid = 1'b0; mem_err = 1'b0; mem_rdata = 32'h0;
        guard = 0;
        while (busy && guard < 50) begin @(negedge clk); guard++; end
        if (guard >= 50) begin
            fails++; $display("FAIL R10 busy actual=1 expected=0 (stuck)");
        end
        irq_req = 1'b0;
        idle(2);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        running = 1;
        @(negedge clk);
        // reset state
        chk("R10", "busy after reset", 32'(busy), 32'd0);
        // R1: request with enable clear is ignored
        irq_req = 1'b1; irq_en = 1'b0; irq_vec = 8'h21;
        idle(5);
        chk("R1", "busy with enable clear", 32'(busy), 32'd0);
        chk("R1", "no read with enable clear", 32'(mem_req), 32'd0);
        irq_req = 1'b0;
        idle(2);
        // kernel mode, status with top bit and high bits set, fast response
        run_irq(8'h05, 1'b0, 32'hFFF0_0C03, 32'h1000, 32'h2000, 32'h4000_0010,
                32'h0000_0800, 32'h0403_0201, 1'b0, 0, 1'b0, 1'b0);
        // user mode, largest vector, slow response
        run_irq(8'hFF, 1'b1, 32'h7ABC_DEF1, 32'hAAAA_0000, 32'h8000_F000, 32'h0000_1234,
                32'h1000_0000, 32'hCAFE_BABE, 1'b0, 3, 1'b0, 1'b0);
        // failed vector read
        run_irq(8'h10, 1'b1, 32'h8000_0001, 32'h10, 32'h20, 32'h30,
                32'h40, 32'h5555_5555, 1'b1, 1, 1'b0, 1'b0);
        // spurious response in request cycle, base wraps, request held while busy
        run_irq(8'h08, 1'b0, 32'h0000_0000, 32'h1, 32'h2, 32'h3,
                32'hFFFF_FFF0, 32'h89AB_CDEF, 1'b0, 2, 1'b1, 1'b1);
        // vector zero
        run_irq(8'h00, 1'b1, 32'h003F_FFFF, 32'hFFFF_FFFC, 32'h0, 32'hFFFF_FFFE,
                32'h0000_0100, 32'h0000_0000, 1'b0, 0, 1'b0, 1'b0);
        chk("R8", "idle at end", 32'(busy), 32'd0);
        running = 0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule